// File: doc/BRIEF.md
# Scaled-Index Add Unit

This execution unit sits in a 64-bit integer pipeline and forms the sum of a base operand and a scaled index operand in a single registered step. The index is multiplied by 2, 4, 8 or 16 by shifting it left. The multiplier comes from a two-bit scale field. The unit is typically used for array element addressing and for small constant multiply-accumulate arithmetic.

There are three variants. The full variant scales the whole 64-bit index. The signed-word variant takes only the lower 32 bits of the index and sign-extends them. The unsigned-word variant takes the lower 32 bits and zero-extends them. An optional record request produces a three-bit sign classification of the result. The operands are presented with a valid strobe. The result, flags and their valid bits appear on registers one clock later.

Top module: `scaled_add_unit`

## Requirements
- R1: The index is shifted left by `scale` + 1 places, so `scale` values 0, 1, 2 and 3 multiply it by 2, 4, 8 and 16.
- R2: With `op_sel` = 2'b00 (full), the result is `base` + (`index` shifted), with all 64 bits of `index` used as an unsigned value.
- R3: With `op_sel` = 2'b01 (signed word), `index[31:0]` is sign-extended from bit 31 to 64 bits and then shifted before it is added to the full `base`.
- R4: With `op_sel` = 2'b10 (unsigned word), `index[31:0]` is zero-extended to 64 bits and then shifted before the add. `index[63:32]` has no effect.
- R5: All arithmetic wraps modulo 2^64. Bits shifted beyond bit 63 and the carry out of the add are dropped, and `res_illegal` stays 0 for every legal `op_sel`.
- R6: `op_sel` = 2'b11 is reserved. It yields `res_value` = 0 and `res_illegal` = 1.
- R7: `res_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and the result reflects the operands sampled in that cycle.
- R8: When `in_valid` and `rec_en` are both high, `flag_valid` rises in the following cycle. `flags` is then one-hot: bit 2 means the result is negative as a signed value, bit 1 means positive, and bit 0 means zero.
- R9: When `rec_en` is low on an accepted operation, `flag_valid` is low in the following cycle and `flags` keeps its previous value.
- R10: While `in_valid` is low, `res_valid` and `flag_valid` drop, and `res_value`, `res_illegal` and `flags` hold their values.
- R11: A synchronous active-high `rst` clears `res_valid`, `flag_valid`, `res_value`, `res_illegal` and `flags` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_sel | input | 2 | Variant: 00 full, 01 signed word, 10 unsigned word, 11 reserved |
| scale | input | 2 | Shift amount minus one |
| rec_en | input | 1 | Request sign-classification flags |
| base | input | 64 | Addend operand |
| index | input | 64 | Operand that is scaled |
| res_valid | output | 1 | Registered result is valid |
| res_value | output | 64 | Registered sum |
| res_illegal | output | 1 | Registered reserved-variant indication |
| flag_valid | output | 1 | Registered flags are fresh |
| flags | output | 3 | Registered {negative, positive, zero} |

## Verification
Every output is produced by one register stage. The sum, the illegal indication, the flags and both valid bits are therefore due at the first rising edge after the cycle that carried `in_valid`. The bench drives the inputs at a falling edge and drops `in_valid` at the next falling edge. It compares the outputs at that same falling edge, which lies half a period after the capturing edge. For the hold checks the bench waits a further full cycle with `in_valid` low and changed operands. It then confirms that nothing moved.

// File: rtl/scaled_add_unit.sv
module scaled_add_unit #(
  parameter int XLEN = 64,
  parameter int SCW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      op_sel,
  input  logic [SCW-1:0]  scale,
  input  logic            rec_en,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  output logic            res_valid,
  output logic [XLEN-1:0] res_value,
  output logic            res_illegal,
  output logic            flag_valid,
  output logic [2:0]      flags
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = SCW + 1;
  localparam logic [1:0] OP_FULL = 2'b00;
  localparam logic [1:0] OP_SWRD = 2'b01;
  localparam logic [1:0] OP_UWRD = 2'b10;

  logic [XLEN-1:0] idx_ext, idx_sh, sum, nxt_val;
  logic [SHW-1:0]  amt;
  logic            bad_op;
  logic [2:0]      nxt_flags;

  assign amt = {1'b0, scale} + SHW'(1);

  always_comb begin
    case (op_sel)
      OP_FULL: idx_ext = index;
      OP_SWRD: idx_ext = {{HALF{index[HALF-1]}}, index[HALF-1:0]};
      OP_UWRD: idx_ext = {{HALF{1'b0}}, index[HALF-1:0]};
      default: idx_ext = '0;
    endcase
  end

  assign idx_sh  = idx_ext << amt;
  assign sum     = base + idx_sh;
  assign bad_op  = (op_sel == 2'b11);
  assign nxt_val = bad_op ? '0 : sum;

  assign nxt_flags = nxt_val[XLEN-1] ? 3'b100 :
                     (nxt_val == '0) ? 3'b001 : 3'b010;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      flag_valid  <= 1'b0;
      res_value   <= '0;
      res_illegal <= 1'b0;
      flags       <= '0;
    end else begin
      res_valid  <= in_valid;
      flag_valid <= in_valid & rec_en;
      if (in_valid) begin
        res_value   <= nxt_val;
        res_illegal <= bad_op;
        if (rec_en) flags <= nxt_flags;
      end
    end
  end
endmodule

// File: rtl/scaled_add_unit_chk.sv
module scaled_add_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      op_sel,
  input logic            rec_en,
  input logic            res_valid,
  input logic [XLEN-1:0] res_value,
  input logic            res_illegal,
  input logic            flag_valid,
  input logic [2:0]      flags
);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  p_valid_drops_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && !flag_valid);
  p_value_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_value) && $stable(res_illegal));
  p_flags_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    flag_valid |-> $countones(flags) == 1);
  p_flags_zero_r8: assert property (@(posedge clk) disable iff (rst)
    flag_valid |-> flags[0] == (res_value == '0));
  p_flags_neg_r8: assert property (@(posedge clk) disable iff (rst)
    flag_valid |-> flags[2] == res_value[XLEN-1]);
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && rec_en) |=> $stable(flags) && !flag_valid);
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_illegal) |-> res_value == '0);
  p_illegal_flag_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_illegal == ($past(op_sel) == 2'b11));
endmodule

bind scaled_add_unit scaled_add_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .rec_en(rec_en),
  .res_valid(res_valid), .res_value(res_value), .res_illegal(res_illegal),
  .flag_valid(flag_valid), .flags(flags)
);

// File: tb/scaled_add_unit_test.sv
module scaled_add_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [1:0]  scale = '0;
  logic        rec_en = 1'b0;
  logic [63:0] base = '0;
  logic [63:0] index = '0;
  logic        res_valid, res_illegal, flag_valid;
  logic [63:0] res_value;
  logic [2:0]  flags;

  int checks = 0;
  int errors = 0;
  logic [2:0] last_flags = '0;

  always #10 clk = ~clk;

  scaled_add_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .scale(scale),
    .rec_en(rec_en), .base(base), .index(index), .res_valid(res_valid),
    .res_value(res_value), .res_illegal(res_illegal), .flag_valid(flag_valid),
    .flags(flags)
  );

  // {op, scale, base, index, expected}
  localparam int NV = 12;
  localparam logic [195:0] VEC [NV] = '{
    {2'd0, 2'd0, 64'd10, 64'd3, 64'd16},
    {2'd0, 2'd3, 64'd1, 64'h10, 64'h101},
    {2'd1, 2'd0, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFE},
    {2'd1, 2'd3, 64'd0, 64'h1234_5678_8000_0000, 64'hFFFF_FFF8_0000_0000},
    {2'd2, 2'd3, 64'd0, 64'h1234_5678_8000_0000, 64'h0000_0008_0000_0000},
    {2'd2, 2'd1, 64'd5, 64'hFFFF_FFFF_0000_0003, 64'h11},
    {2'd0, 2'd2, 64'h8, 64'h2000_0000_0000_0000, 64'h8},
    {2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd1},
    {2'd1, 2'd2, 64'h40, 64'h0000_0000_FFFF_FFF8, 64'd0},
    {2'd3, 2'd1, 64'd123, 64'd456, 64'd0},
    {2'd0, 2'd1, 64'd0, 64'h0800_0000_0000_0000, 64'h2000_0000_0000_0000},
    {2'd1, 2'd1, 64'd0, 64'h0000_0000_7FFF_FFFF, 64'h1_FFFF_FFFC}
  };

  function automatic logic [63:0] ref_calc(input logic [1:0] op, input logic [1:0] sc,
                                           input logic [63:0] a, input logic [63:0] b);
    logic [63:0] mul, n;
    mul = 64'd2 << sc;
    if (op == 2'd0) n = b;
    else if (op == 2'd1) n = b[31] ? (b | 64'hFFFF_FFFF_0000_0000) : (b & 64'hFFFF_FFFF);
    else n = b & 64'hFFFF_FFFF;
    return (op == 2'd3) ? 64'd0 : a + n * mul;
  endfunction

  function automatic logic [2:0] ref_flags(input logic [63:0] v);
    if ($signed(v) < 0) return 3'b100;
    if (v == 0) return 3'b001;
    return 3'b010;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic [1:0] sc,
                        input logic [63:0] a, input logic [63:0] b, input logic rec,
                        input logic [63:0] exp);
    op_sel = op; scale = sc; base = a; index = b; rec_en = rec; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R7 valid"}, 64'(res_valid), 64'd1);
    chk({req, " value"}, res_value, exp);
    chk({req, " R5/R6 illegal"}, 64'(res_illegal), 64'(op == 2'd3));
    chk({req, " R8/R9 flag_valid"}, 64'(flag_valid), 64'(rec));
    if (rec) last_flags = ref_flags(exp);
    chk({req, " R8/R9 flags"}, 64'(flags), 64'(last_flags));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 res_valid", 64'(res_valid), 64'd0);
    chk("R11 flag_valid", 64'(flag_valid), 64'd0);
    chk("R11 value", res_value, 64'd0);
    chk("R11 flags", 64'(flags), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // table: R2 R3 R4 R5 R6 vectors; rec alternates
    for (int i = 0; i < NV; i++) begin
      logic [195:0] v;
      v = VEC[i];
      chk("R2/R3/R4 table vs reference", ref_calc(v[195:194], v[193:192], v[191:128], v[127:64]), v[63:0]);
      run_op("R2/R3/R4/R5/R6 table", v[195:194], v[193:192], v[191:128], v[127:64], i[0], v[63:0]);
    end

    // R1 all shift amounts, every variant
    for (int op = 0; op < 4; op++) begin
      for (int sc = 0; sc < 4; sc++) begin
        run_op("R1 sweep", 2'(op), 2'(sc), 64'h0123_4567_89AB_CDEF,
               64'hFEDC_BA98_F000_0001, 1'b1,
               ref_calc(2'(op), 2'(sc), 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_F000_0001));
      end
    end

    // R4 upper half of index ignored
    run_op("R4 upper ignored", 2'd2, 2'd0, 64'd7, 64'hAAAA_AAAA_0000_0004, 1'b1, 64'd15);
    run_op("R4 upper ignored", 2'd2, 2'd0, 64'd7, 64'h5555_5555_0000_0004, 1'b1, 64'd15);

    // R9 record clear keeps flags (previous flags positive)
    run_op("R9 no record", 2'd1, 2'd0, 64'd0, 64'h8000_0000, 1'b0, 64'hFFFF_FFFF_0000_0000);

    // R10 hold with in_valid low and changed operands
    op_sel = 2'd3; base = 64'hDEAD; index = 64'hBEEF; rec_en = 1'b1;
    @(negedge clk);
    chk("R10 res_valid low", 64'(res_valid), 64'd0);
    chk("R10 flag_valid low", 64'(flag_valid), 64'd0);
    chk("R10 value held", res_value, 64'hFFFF_FFFF_0000_0000);
    chk("R10 illegal held", 64'(res_illegal), 64'd0);
    chk("R10 flags held", 64'(flags), 64'(last_flags));

    // R11 reset after activity
    run_op("R8 negative", 2'd0, 2'd0, 64'd0, 64'h8000_0000_0000_0000, 1'b1, 64'd0);
    run_op("R8 negative", 2'd0, 2'd0, 64'd0, 64'h4000_0000_0000_0000, 1'b1, 64'h8000_0000_0000_0000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 value cleared", res_value, 64'd0);
    chk("R11 flags cleared", 64'(flags), 64'd0);
    chk("R11 valid cleared", 64'(res_valid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule